// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Sequencer

This block drives the two gate signals of one half-bridge leg. It takes an on/off command for the upper device and one for the lower device. The pair is read as a 2-bit word, {top, bottom}. The block moves the leg through three legal states: both off, only the upper device on, and only the lower device on. It never drives both gates high.

Any hand-over from one device to the other goes through the both-off state. The incoming device is released only after both gates have been low for a programmable number of clock cycles. A command to switch on both devices is rejected: the leg keeps whatever it is doing. When the incoming commands already contain a long enough both-off gap, the block adds no delay of its own, and the gates follow the commands with a fixed one-cycle latency.

A mode input lets the controller supply only the upper command; the lower command is then its complement. A force-off input clears both gates on the next clock. The gate outputs come straight from flip-flops.

Top module: `leg_deadtime_seq`

## Requirements
- R1: `gate_top` and `gate_bot` are never high in the same cycle.
- R2: The output pair never changes from {1,0} to {0,1}, or from {0,1} to {1,0}, in a single clock; the pair {0,0} always lies between them.
- R3: A gate rises only after both gates have been low for at least `dt_cycles` consecutive cycles, where `dt_cycles` is at least 1.
- R4: While one gate is high, a command of top=1 and bottom=1 leaves both gates unchanged.
- R5: A gate that is high stays high for as long as its command is held.
- R6: If the command shows both-off for at least `dt_cycles` cycles before a new device is requested, that gate rises on the first clock edge that samples the request.
- R7: While both gates are low, a command of top=1 and bottom=1 keeps them low.
- R8: When `single_mode` is 1, the bottom command is the inverse of `pwm_top`, and `pwm_bot` has no effect on the gates.
- R9: When `force_off` is 1 at a clock edge, both gates are low after that edge, regardless of the commands.
- R10: Synchronous active-high `rst` clears both gates. After reset, the first gate to turn on waits `dt_cycles` cycles, counted from the last reset edge.
- R11: A gate that is high falls on the first edge that samples a command that drops it, or that requests the other device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dt_cycles | input | CNT_W | Dead time in clock cycles (at least 1) |
| single_mode | input | 1 | 1: bottom command = inverse of `pwm_top`; 0: independent commands |
| force_off | input | 1 | Drives both gates low at the next edge |
| pwm_top | input | 1 | Upper device command |
| pwm_bot | input | 1 | Lower device command (ignored in single mode) |
| gate_top | output | 1 | Registered upper gate drive |
| gate_bot | output | 1 | Registered lower gate drive |

## Verification
The bench keeps the default counter width of 10 bits and drives `dt_cycles` through the port. It sweeps dead times of 1 to 6 cycles in both command modes, with random commands held for 1 to 8 cycles. These short dead times put command gaps just below, equal to and above the dead time within reach, together with force-off pulses and both-on commands arriving in every state. Directed cases check reset, rejection of the both-on command, swaps, the exact turn-on edge and the ignored bottom input in single mode. One run uses 500 cycles, which is 2 µs at the bench clock.

// File: rtl/dts_pkg.sv
package dts_pkg;

  // Encoding {top, bottom}; bit 1 drives the upper gate, bit 0 the lower gate.
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_state_t;

  localparam logic [1:0] CMD_BOTH = 2'b11;

endpackage

// File: rtl/dts_cmd_sel.sv
module dts_cmd_sel (
  input  logic       single_mode,
  input  logic       pwm_top,
  input  logic       pwm_bot,
  output logic [1:0] cmd
);

  always_comb begin
    if (single_mode) begin
      cmd = {pwm_top, ~pwm_top};
    end else begin
      cmd = {pwm_top, pwm_bot};
    end
  end

endmodule

// File: rtl/dts_gap_timer.sv
module dts_gap_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dt_cycles,
  input  logic             leg_off,
  output logic             ready
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cnt_plus;

  // The present cycle counts as one both-off cycle, hence cnt + 1.
  assign cnt_plus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign ready    = cnt_plus >= {1'b0, dt_cycles};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!leg_off) begin
      cnt <= '0;
    end else if (!ready) begin
      cnt <= cnt_plus[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/dts_leg_fsm.sv
module dts_leg_fsm
  import dts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       force_off,
  input  logic [1:0] cmd,
  input  logic       ready,
  output logic       leg_off,
  output logic       gate_top,
  output logic       gate_bot
);

  leg_state_t state_q;
  leg_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = LEG_OFF;
    end else begin
      unique case (state_q)
        LEG_OFF: begin
          if (ready && cmd == 2'(LEG_HI)) begin
            state_d = LEG_HI;
          end else if (ready && cmd == 2'(LEG_LO)) begin
            state_d = LEG_LO;
          end
        end
        LEG_HI: begin
          if (cmd != 2'(LEG_HI) && cmd != CMD_BOTH) begin
            state_d = LEG_OFF;
          end
        end
        LEG_LO: begin
          if (cmd != 2'(LEG_LO) && cmd != CMD_BOTH) begin
            state_d = LEG_OFF;
          end
        end
        default: state_d = LEG_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LEG_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign leg_off  = (state_q == LEG_OFF);
  assign gate_top = state_q[1];
  assign gate_bot = state_q[0];

endmodule

// File: rtl/leg_deadtime_seq.sv
module leg_deadtime_seq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dt_cycles,
  input  logic             single_mode,
  input  logic             force_off,
  input  logic             pwm_top,
  input  logic             pwm_bot,
  output logic             gate_top,
  output logic             gate_bot
);

  logic [1:0] cmd;
  logic       ready;
  logic       leg_off;

  dts_cmd_sel u_sel (
    .single_mode (single_mode),
    .pwm_top     (pwm_top),
    .pwm_bot     (pwm_bot),
    .cmd         (cmd)
  );

  dts_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .dt_cycles (dt_cycles),
    .leg_off   (leg_off),
    .ready     (ready)
  );

  dts_leg_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .force_off (force_off),
    .cmd       (cmd),
    .ready     (ready),
    .leg_off   (leg_off),
    .gate_top  (gate_top),
    .gate_bot  (gate_bot)
  );

endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] dt_cycles,
  input logic             single_mode,
  input logic             force_off,
  input logic             pwm_top,
  input logic             pwm_bot,
  input logic             gate_top,
  input logic             gate_bot
);

  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] off_seen;
  logic             cmd_b;
  logic             both_low;

  assign cmd_b    = single_mode ? ~pwm_top : pwm_bot;
  assign both_low = !gate_top && !gate_bot;

  // Counts earlier consecutive cycles with both gates low.
  always_ff @(posedge clk) begin
    if (rst) begin
      off_seen <= '0;
    end else if (!both_low) begin
      off_seen <= '0;
    end else if (off_seen != {EXT_W{1'b1}}) begin
      off_seen <= off_seen + 1'b1;
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(gate_top && gate_bot)); // R1

  AST_NO_SWAP_TOP: assert property (@(posedge clk) disable iff (rst)
    gate_top |=> !gate_bot); // R2

  AST_NO_SWAP_BOT: assert property (@(posedge clk) disable iff (rst)
    gate_bot |=> !gate_top); // R2

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (both_low && ((off_seen + 1'b1) < {1'b0, dt_cycles})) |=> both_low); // R3

  AST_BOTH_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!force_off && pwm_top && cmd_b && !both_low) |=> $stable({gate_top, gate_bot})); // R4

  AST_BOTH_CMD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!force_off && pwm_top && cmd_b && both_low) |=> both_low); // R7

  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
    force_off |=> both_low); // R9

endmodule

bind leg_deadtime_seq dts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dt_cycles   (dt_cycles),
  .single_mode (single_mode),
  .force_off   (force_off),
  .pwm_top     (pwm_top),
  .pwm_bot     (pwm_bot),
  .gate_top    (gate_top),
  .gate_bot    (gate_bot)
);

// File: tb/sim_leg_deadtime_seq.sv
`timescale 1ns/1ps
module sim_leg_deadtime_seq;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] dt_cycles = 10'd3;
  logic             single_mode = 1'b0;
  logic             force_off = 1'b0;
  logic             pwm_top = 1'b0;
  logic             pwm_bot = 1'b0;
  logic             gate_top;
  logic             gate_bot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  leg_deadtime_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .dt_cycles(dt_cycles), .single_mode(single_mode),
    .force_off(force_off), .pwm_top(pwm_top), .pwm_bot(pwm_bot),
    .gate_top(gate_top), .gate_bot(gate_bot)
  );

  // Behavioural expectation built from the requirements.
  logic [1:0] exp_q = 2'b00;
  int         off_run = 1;
  bit         model_ok = 1'b0;

  always @(posedge clk) begin
    logic [1:0] c;
    logic [1:0] n;
    c = {pwm_top, single_mode ? ~pwm_top : pwm_bot};
    if (rst) begin
      exp_q    <= 2'b00;
      off_run  <= 1;
      model_ok <= 1'b1;
    end else begin
      if (force_off) n = 2'b00;
      else if (exp_q == 2'b00) n = ((c == 2'b01 || c == 2'b10) && off_run >= int'(dt_cycles)) ? c : 2'b00;
      else if (c == exp_q || c == 2'b11) n = exp_q;
      else n = 2'b00;
      exp_q   <= n;
      off_run <= (n != 2'b00) ? 0 : ((exp_q == 2'b00) ? off_run + 1 : 1);
    end
  end

  always @(negedge clk) begin
    if (model_ok && !done) begin
      checks++;
      if ({gate_top, gate_bot} !== exp_q) begin
        errors++;
        $display("FAIL R3 model sweep: got %b expected %b (dt=%0d mode=%0b)",
                 {gate_top, gate_bot}, exp_q, dt_cycles, single_mode);
      end
      checks++;
      if (gate_top && gate_bot) begin
        errors++;
        $display("FAIL R1: got 11 expected not 11");
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string tag, input logic [1:0] want);
    checks++;
    if ({gate_top, gate_bot} !== want) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, {gate_top, gate_bot}, want);
    end
  endtask

  task automatic do_reset(input int dt, input bit mode);
    rst = 1'b1;
    dt_cycles = CNT_W'(dt);
    single_mode = mode;
    force_off = 1'b0;
    pwm_top = 1'b0;
    pwm_bot = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    done = 1'b1;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    @(negedge clk);

    // R10: reset state and first turn-on wait
    do_reset(3, 1'b0);
    expect_out("R10 reset", 2'b00);
    pwm_top = 1'b1;
    tick(2);
    expect_out("R10 first turn-on waits", 2'b00);
    tick(1);
    expect_out("R10 first turn-on at dt", 2'b10);

    // R5: hold
    tick(50);
    expect_out("R5 hold high", 2'b10);

    // R4: both-on command while top is on
    pwm_bot = 1'b1;
    tick(1);
    expect_out("R4 both-on held", 2'b10);
    tick(4);
    expect_out("R4 both-on held long", 2'b10);

    // R2 / R3 / R11: direct swap request
    pwm_top = 1'b0;
    tick(1);
    expect_out("R11 swap turns off first", 2'b00);
    expect_out("R2 no direct swap", 2'b00);
    tick(2);
    expect_out("R3 still in dead time", 2'b00);
    tick(1);
    expect_out("R3 on after dead time", 2'b01);

    // R6: command already has a long enough gap
    pwm_bot = 1'b0;
    tick(3);
    expect_out("R6 gap in command", 2'b00);
    pwm_top = 1'b1;
    tick(1);
    expect_out("R6 no added delay", 2'b10);

    // R7: both-on while off
    pwm_top = 1'b0;
    tick(1);
    pwm_top = 1'b1;
    pwm_bot = 1'b1;
    tick(10);
    expect_out("R7 both-on while off", 2'b00);

    // R9: force off
    pwm_bot = 1'b0;
    tick(5);
    expect_out("R9 precondition on", 2'b10);
    force_off = 1'b1;
    tick(1);
    expect_out("R9 forced off", 2'b00);
    tick(6);
    expect_out("R9 forced off held", 2'b00);
    force_off = 1'b0;

    // R8: single mode, bottom ignored
    do_reset(3, 1'b1);
    pwm_top = 1'b0;
    tick(3);
    expect_out("R8 complement drives bottom", 2'b01);
    for (int k = 0; k < 6; k++) begin
      pwm_bot = ~pwm_bot;
      tick(1);
      expect_out("R8 bottom input ignored", 2'b01);
    end
    pwm_top = 1'b1;
    tick(1);
    expect_out("R8 top request off first", 2'b00);
    tick(3);
    expect_out("R8 top on after dead time", 2'b10);

    // R10 / R3: 2 us dead time at 250 MHz
    do_reset(500, 1'b0);
    pwm_bot = 1'b1;
    tick(499);
    expect_out("R10 long dead time wait", 2'b00);
    tick(1);
    expect_out("R10 long dead time on", 2'b01);

    // R3: random sweep over dead time and mode
    for (int dt = 1; dt <= 6; dt++) begin
      for (int m = 0; m < 2; m++) begin
        do_reset(dt, m[0]);
        for (int s = 0; s < 1000; s++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          pwm_top   = lfsr[8];
          pwm_bot   = lfsr[9];
          force_off = (lfsr[15:12] == 4'd0);
          tick(int'(lfsr[2:0]) + 1);
        end
      end
    end

    done = 1'b1;
    report();
  end

endmodule